// File: doc/BRIEF.md
# DMA Bus-Bandwidth Scheduler

This block decides, cycle by cycle, whether a shared address/data bus belongs to the processor or to a three-channel DMA engine. Eight peripheral request lines and eight software force bits form the request inputs. A force bit acts exactly as if its matching request line had been raised. Each channel has an enable bit and a 3-bit field that picks one of the eight inputs. An enabled channel whose chosen input fires latches a pending request. The input order is: timer channels 0 to 3, SPI transmit, SPI receive, SCI receive, SCI transmit.

When no transfer is running, the scheduler starts one for the lowest-numbered pending channel. A byte transfer takes two DMA bus cycles and a 16-bit word transfer takes four. Those cycles are handed out according to a 2-bit bandwidth field, and every cycle the DMA does not take goes to the processor. A wait-mode input, together with a wait-run enable, decides whether the DMA may keep using the bus while the processor sleeps. Address arithmetic and interrupt generation are left to neighbouring blocks. The scheduler only reports which channel owns the bus, whether the current cycle is a read or a write, and when a transfer ends.

Top module: `dma_bw_sched`

## Requirements
- R1: After reset the processor owns the bus: `bus_cpu`=1, `bus_dma`=0 and `xfer_done`=0 until a request arrives.
- R2: Channel c becomes pending one cycle after an edge at which `chan_en[c]`=1 and input number `chan_sel[3c+2:3c]` is high. Input numbers are 0-3 timer channel 0-3, 4 SPI transmit, 5 SPI receive, 6 SCI receive and 7 SCI transmit.
- R3: `sw_force[k]` has the same effect as `periph_req[k]`. It has no effect on a channel that is disabled or that selects another input.
- R4: When several channels are pending while the scheduler is idle, channel 0 is served first and channel 2 last.
- R5: A transfer for a channel with `chan_word[c]`=0 takes 2 DMA bus cycles, write flags 0 then 1. With `chan_word[c]`=1 it takes 4 DMA bus cycles with write flags 0,1,0,1. `xfer_chan` names the channel.
- R6: `bw_sel`=00 (25%): the DMA owns the first cycle of a transfer and then one cycle in every four.
- R7: `bw_sel`=01 gives one DMA cycle in every two. `bw_sel`=10 gives the repeating pattern DMA, DMA, processor. `bw_sel`=11 gives every cycle of the transfer to the DMA. Each pattern starts at the first cycle of the transfer.
- R8: In every cycle exactly one of `bus_dma` and `bus_cpu` is 1.
- R9: While `cpu_wait`=1 and `wait_run_en`=0 the DMA takes no bus cycle and starts no transfer. The slot pattern and the transfer position are frozen and resume where they stopped. With `wait_run_en`=1, `cpu_wait` has no effect.
- R10: `xfer_done` pulses in the last DMA cycle of a transfer. In the cycle that follows, the processor owns the bus, and that channel's pending request is cleared unless a new request for it arrived in that same cycle.
- R11: Clearing `chan_en[c]` discards the pending request of channel c, so no transfer for it starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| periph_req | input | 8 | Peripheral request lines, one per input number |
| sw_force | input | 8 | Software force bits, one per input number |
| chan_en | input | 3 | Per-channel enable |
| chan_sel | input | 9 | Per-channel 3-bit input select, channel c at bits 3c+2:3c |
| chan_word | input | 3 | Per-channel transfer size, 1 = 16-bit word |
| bw_sel | input | 2 | DMA bandwidth share |
| cpu_wait | input | 1 | Processor is in wait mode |
| wait_run_en | input | 1 | Let DMA run during wait mode |
| bus_dma | output | 1 | DMA owns the bus this cycle |
| bus_cpu | output | 1 | Processor owns the bus this cycle |
| xfer_chan | output | 2 | Channel of the current transfer |
| xfer_write | output | 1 | Current DMA cycle is the write half |
| xfer_done | output | 1 | Last DMA cycle of a transfer |

## Verification
Directed cases check each bandwidth setting with both byte and word transfers. Counting the cycles from the first DMA cycle to the done pulse tells the 25%, 67% and full patterns apart. A single source shared by all three channels shows the service order. Force bits aimed at a disabled channel, or at a channel that selects another input, must cause no bus cycle. A wait pulse in the middle of a word transfer has to stretch it by exactly its own length. Long random runs mix sparse requests, force bits, enable and select changes, bandwidth switches in the middle of a transfer and wait toggling, and a cycle-level reference model follows them. These runs expose ordering and slot-counting slips that the directed cases cannot reach.

// File: rtl/dmasch_pkg.sv
package dmasch_pkg;

  typedef enum logic [1:0] {
    BW_QUARTER    = 2'b00,
    BW_HALF       = 2'b01,
    BW_TWO_THIRDS = 2'b10,
    BW_FULL       = 2'b11
  } bw_e;

  localparam int BYTE_BEATS = 2;
  localparam int WORD_BEATS = 4;
  localparam int BEATW      = $clog2(WORD_BEATS);
  localparam int SLOTW      = 2;

  // index of the final slot in the repeating pattern
  function automatic logic [SLOTW-1:0] slot_final(bw_e b);
    case (b)
      BW_QUARTER:    slot_final = 2'd3;
      BW_HALF:       slot_final = 2'd1;
      BW_TWO_THIRDS: slot_final = 2'd2;
      default:       slot_final = 2'd0;
    endcase
  endfunction

  // does this slot belong to the DMA
  function automatic logic slot_for_dma(bw_e b, logic [SLOTW-1:0] s);
    case (b)
      BW_QUARTER:    slot_for_dma = (s == 2'd0);
      BW_HALF:       slot_for_dma = (s == 2'd0);
      BW_TWO_THIRDS: slot_for_dma = (s < 2'd2);
      default:       slot_for_dma = 1'b1;
    endcase
  endfunction

endpackage

// File: rtl/dmasch_req_router.sv
module dmasch_req_router #(
  parameter int NCH  = 3,
  parameter int NSRC = 8,
  localparam int SELW = $clog2(NSRC)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NSRC-1:0]     periph_req,
  input  logic [NSRC-1:0]     sw_force,
  input  logic [NCH-1:0]      chan_en,
  input  logic [NCH*SELW-1:0] chan_sel,
  input  logic [NCH-1:0]      done_vec,
  output logic [NCH-1:0]      pend_q
);

  logic [NSRC-1:0] src_all;
  logic [NCH-1:0]  hit;
  logic [NCH-1:0]  pend_d;

  assign src_all = periph_req | sw_force;

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    always_comb begin
      hit[c]    = chan_en[c] & src_all[chan_sel[c*SELW +: SELW]];
      pend_d[c] = hit[c] | (pend_q[c] & chan_en[c] & ~done_vec[c]);
    end

    // R11: a disabled channel keeps no pending request
    a_r11_disable_drops: assert property (@(posedge clk) disable iff (!rst_n)
      !chan_en[c] |=> !pend_q[c]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

endmodule

// File: rtl/dmasch_picker.sv
module dmasch_picker #(
  parameter int NCH = 3,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] pend,
  output logic [NCH-1:0] pick_oh,
  output logic [CHW-1:0] pick_idx,
  output logic           pick_any
);

  logic [NCH:0] seen;
  assign seen[0] = 1'b0;

  for (genvar i = 0; i < NCH; i++) begin : g_prio
    assign pick_oh[i]  = pend[i] & ~seen[i];
    assign seen[i+1]   = seen[i] | pend[i];
  end

  assign pick_any = seen[NCH];

  always_comb begin
    pick_idx = '0;
    for (int i = 0; i < NCH; i++) begin
      if (pick_oh[i]) pick_idx = CHW'(i);
    end
  end

  // R4: at most one winner, and it is the lowest pending channel
  a_r4_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pick_oh));
  a_r4_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
    pend[0] |-> (pick_oh == NCH'(1)));

endmodule

// File: rtl/dmasch_pacer.sv
module dmasch_pacer
  import dmasch_pkg::*;
#(
  parameter int NCH = 3,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [CHW-1:0] start_chan,
  input  logic           start_word,
  input  logic [1:0]     bw,
  input  logic           susp,
  output logic           active,
  output logic           grant,
  output logic           write,
  output logic           last,
  output logic [CHW-1:0] chan
);

  logic             active_q, active_d;
  logic [CHW-1:0]   chan_q, chan_d;
  logic [BEATW-1:0] beat_q, beat_d;
  logic [BEATW-1:0] fin_q, fin_d;
  logic [SLOTW-1:0] slot_q, slot_d;
  bw_e              bw_v;

  assign bw_v   = bw_e'(bw);
  assign active = active_q;
  assign chan   = chan_q;
  assign grant  = active_q & ~susp & slot_for_dma(bw_v, slot_q);
  assign write  = beat_q[0];
  assign last   = grant & (beat_q == fin_q);

  always_comb begin
    active_d = active_q;
    chan_d   = chan_q;
    beat_d   = beat_q;
    fin_d    = fin_q;
    slot_d   = slot_q;
    if (active_q) begin
      if (!susp) begin
        slot_d = (slot_q >= slot_final(bw_v)) ? '0 : slot_q + 1'b1;
        if (grant) beat_d = beat_q + 1'b1;
        if (last)  active_d = 1'b0;
      end
    end else if (start) begin
      active_d = 1'b1;
      chan_d   = start_chan;
      beat_d   = '0;
      slot_d   = '0;
      fin_d    = start_word ? BEATW'(WORD_BEATS - 1) : BEATW'(BYTE_BEATS - 1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      chan_q   <= '0;
      beat_q   <= '0;
      fin_q    <= '0;
      slot_q   <= '0;
    end else begin
      active_q <= active_d;
      chan_q   <= chan_d;
      beat_q   <= beat_d;
      fin_q    <= fin_d;
      slot_q   <= slot_d;
    end
  end

  // R9: suspension freezes the transfer position and slot pattern
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && susp) |=> ($stable(beat_q) && $stable(slot_q)));

  // R6: at quarter bandwidth a DMA cycle is never followed by another
  a_r6_quarter_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (bw_v == BW_QUARTER && grant) |=> (!grant || bw_v != BW_QUARTER));

endmodule

// File: rtl/dma_bw_sched.sv
module dma_bw_sched #(
  parameter int NCH  = 3,
  parameter int NSRC = 8,
  localparam int SELW = $clog2(NSRC),
  localparam int CHW  = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NSRC-1:0]     periph_req,
  input  logic [NSRC-1:0]     sw_force,
  input  logic [NCH-1:0]      chan_en,
  input  logic [NCH*SELW-1:0] chan_sel,
  input  logic [NCH-1:0]      chan_word,
  input  logic [1:0]          bw_sel,
  input  logic                cpu_wait,
  input  logic                wait_run_en,
  output logic                bus_dma,
  output logic                bus_cpu,
  output logic [CHW-1:0]      xfer_chan,
  output logic                xfer_write,
  output logic                xfer_done
);

  logic [NCH-1:0] pend_q;
  logic [NCH-1:0] done_vec;
  logic [NCH-1:0] pick_oh;
  logic [CHW-1:0] pick_idx;
  logic           pick_any;
  logic           susp;
  logic           active;
  logic           start;
  logic           grant;
  logic           last;
  logic [CHW-1:0] chan;

  assign susp  = cpu_wait & ~wait_run_en;
  assign start = ~active & pick_any & ~susp;

  always_comb begin
    done_vec = '0;
    if (last) done_vec[chan] = 1'b1;
  end

  dmasch_req_router #(.NCH(NCH), .NSRC(NSRC)) u_router (
    .clk        (clk),
    .rst_n      (rst_n),
    .periph_req (periph_req),
    .sw_force   (sw_force),
    .chan_en    (chan_en),
    .chan_sel   (chan_sel),
    .done_vec   (done_vec),
    .pend_q     (pend_q)
  );

  dmasch_picker #(.NCH(NCH)) u_picker (
    .clk      (clk),
    .rst_n    (rst_n),
    .pend     (pend_q),
    .pick_oh  (pick_oh),
    .pick_idx (pick_idx),
    .pick_any (pick_any)
  );

  dmasch_pacer #(.NCH(NCH)) u_pacer (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .start_chan (pick_idx),
    .start_word (chan_word[pick_idx]),
    .bw         (bw_sel),
    .susp       (susp),
    .active     (active),
    .grant      (grant),
    .write      (xfer_write),
    .last       (last),
    .chan       (chan)
  );

  assign bus_dma   = grant;
  assign bus_cpu   = ~grant;
  assign xfer_chan = chan;
  assign xfer_done = last;

  // R10: the cycle after a done pulse belongs to the processor
  a_r10_gap_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> !bus_dma);

  // R2: a started transfer belongs to a channel that was pending
  a_r2_start_pending: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> pend_q[pick_idx]);

endmodule

// File: tb/sim_dma_bw_sched.sv
`timescale 1ns/1ps
module sim_dma_bw_sched;

  logic       clk;
  logic       rst_n;
  logic [7:0] periph_req, sw_force;
  logic [2:0] chan_en, chan_word;
  logic [8:0] chan_sel;
  logic [1:0] bw_sel;
  logic       cpu_wait, wait_run_en;
  logic       bus_dma, bus_cpu, xfer_write, xfer_done;
  logic [1:0] xfer_chan;

  int total, bad, cyc_n;
  int g_cnt, d_cnt, first_g, first_ch, done_at;

  // reference model state
  logic [2:0] m_pend;
  logic       m_act;
  int         m_ch, m_beat, m_slot, m_fin;

  dma_bw_sched u0 (
    .clk(clk), .rst_n(rst_n), .periph_req(periph_req), .sw_force(sw_force),
    .chan_en(chan_en), .chan_sel(chan_sel), .chan_word(chan_word),
    .bw_sel(bw_sel), .cpu_wait(cpu_wait), .wait_run_en(wait_run_en),
    .bus_dma(bus_dma), .bus_cpu(bus_cpu), .xfer_chan(xfer_chan),
    .xfer_write(xfer_write), .xfer_done(xfer_done)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic bit m_slot_ok(int bw, int s);
    case (bw)
      0: return s == 0;
      1: return s == 0;
      2: return s < 2;
      default: return 1'b1;
    endcase
  endfunction

  function automatic int m_slot_last(int bw);
    case (bw)
      0: return 3;
      1: return 1;
      2: return 2;
      default: return 0;
    endcase
  endfunction

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", req, cyc_n, act, exp);
    end
  endtask

  // compare outputs with the model, then advance the model by one edge
  task automatic cyc();
    bit susp, gr, dn;
    logic [7:0] srcs;
    logic [2:0] np;
    #1;
    susp = cpu_wait && !wait_run_en;
    gr   = m_act && !susp && m_slot_ok(int'(bw_sel), m_slot);
    dn   = gr && (m_beat == m_fin);
    check("R6 R7 R9 bus_dma", int'(bus_dma), int'(gr));
    check("R8 bus_cpu", int'(bus_cpu), int'(!bus_dma));
    check("R10 xfer_done", int'(xfer_done), int'(dn));
    if (gr) begin
      check("R2 R3 R4 xfer_chan", int'(xfer_chan), m_ch);
      check("R5 xfer_write", int'(xfer_write), m_beat % 2);
    end
    if (bus_dma) begin
      if (g_cnt == 0) begin first_g = cyc_n; first_ch = int'(xfer_chan); end
      g_cnt++;
    end
    if (xfer_done) begin d_cnt++; done_at = cyc_n; end
    srcs = periph_req | sw_force;
    for (int c = 0; c < 3; c++) begin
      bit hit;
      hit = chan_en[c] && srcs[chan_sel[3*c +: 3]];
      np[c] = hit || (m_pend[c] && chan_en[c] && !(dn && m_ch == c));
    end
    if (m_act) begin
      if (!susp) begin
        m_slot = (m_slot >= m_slot_last(int'(bw_sel))) ? 0 : m_slot + 1;
        if (gr) m_beat++;
        if (dn) m_act = 1'b0;
      end
    end else if (!susp && m_pend != 3'b000) begin
      m_ch   = m_pend[0] ? 0 : (m_pend[1] ? 1 : 2);
      m_act  = 1'b1;
      m_beat = 0;
      m_slot = 0;
      m_fin  = chan_word[m_ch] ? 3 : 1;
    end
    m_pend = np;
    cyc_n++;
    @(negedge clk);
  endtask

  task automatic clear_trace();
    g_cnt = 0; d_cnt = 0; first_g = -1; first_ch = -1; done_at = -1;
  endtask

  task automatic idle_n(int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  initial begin
    #(8 * 200000);
    bad++;
    $display("FAIL watchdog expired: actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int seed_v;
    total = 0; bad = 0; cyc_n = 0;
    rst_n = 1'b0;
    periph_req = '0; sw_force = '0; chan_en = '0; chan_word = '0;
    chan_sel = '0; bw_sel = 2'b11; cpu_wait = 1'b0; wait_run_en = 1'b0;
    m_pend = '0; m_act = 1'b0; m_ch = 0; m_beat = 0; m_slot = 0; m_fin = 1;
    clear_trace();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    #1;
    check("R1 bus_dma", int'(bus_dma), 0);
    check("R1 bus_cpu", int'(bus_cpu), 1);
    check("R1 xfer_done", int'(xfer_done), 0);
    @(negedge clk);
    idle_n(3);

    // R3: force bit to a channel with another source, and to a disabled one
    clear_trace();
    chan_en = 3'b001; chan_sel = {3'd7, 3'd7, 3'd2};
    sw_force = 8'h20; cyc(); sw_force = 8'h80; cyc(); sw_force = '0;
    idle_n(8);
    check("R3 no grant from unmatched force", g_cnt, 0);

    // R3 + R4: same forced source on all channels, ch0 first, all served
    clear_trace();
    chan_en = 3'b111; chan_sel = {3'd4, 3'd4, 3'd4}; chan_word = 3'b000;
    bw_sel = 2'b11;
    sw_force = 8'h10; cyc(); sw_force = '0;
    idle_n(14);
    check("R4 first channel served", first_ch, 0);
    check("R3 R4 all three served", d_cnt, 3);

    // R6: byte at 25 percent, done four cycles after first grant
    clear_trace();
    chan_en = 3'b001; chan_sel = {3'd0, 3'd0, 3'd1}; bw_sel = 2'b00;
    periph_req = 8'h02; cyc(); periph_req = '0;
    idle_n(10);
    check("R6 quarter byte span", done_at - first_g, 4);
    check("R5 byte beats", g_cnt, 2);

    // R7: word at 67 percent: D D C D D
    clear_trace();
    chan_word = 3'b001; bw_sel = 2'b10;
    periph_req = 8'h02; cyc(); periph_req = '0;
    idle_n(10);
    check("R7 two-thirds word span", done_at - first_g, 4);
    check("R5 word beats", g_cnt, 4);

    // R9: wait suspends a full-rate word transfer for five cycles
    clear_trace();
    bw_sel = 2'b11;
    periph_req = 8'h02; cyc(); periph_req = '0;
    cyc(); cyc();
    cpu_wait = 1'b1; idle_n(5); cpu_wait = 1'b0;
    idle_n(8);
    check("R9 suspended span", done_at - first_g, 8);
    check("R9 word beats after resume", g_cnt, 4);

    // R9: wait-run enable lets transfers continue
    clear_trace();
    wait_run_en = 1'b1; cpu_wait = 1'b1;
    periph_req = 8'h02; cyc(); periph_req = '0;
    idle_n(8);
    check("R9 runs during wait", d_cnt, 1);
    cpu_wait = 1'b0; wait_run_en = 1'b0;

    // R11: disabling a pending channel discards its request
    clear_trace();
    cpu_wait = 1'b1;
    periph_req = 8'h02; cyc(); periph_req = '0;
    chan_en = 3'b000; cyc(); cpu_wait = 1'b0; chan_en = 3'b001;
    idle_n(8);
    check("R11 dropped request", g_cnt, 0);

    // random phase
    seed_v = $urandom(32'h5eed_0042);
    for (int i = 0; i < 20000; i++) begin
      periph_req = '0; sw_force = '0;
      for (int b = 0; b < 8; b++) begin
        if ($urandom_range(15) == 0) periph_req[b] = 1'b1;
        if ($urandom_range(31) == 0) sw_force[b] = 1'b1;
      end
      if ($urandom_range(31) == 0) chan_en = 3'($urandom_range(7));
      if ($urandom_range(31) == 0) chan_sel = 9'($urandom_range(511));
      if ($urandom_range(15) == 0) chan_word = 3'($urandom_range(7));
      if ($urandom_range(15) == 0) bw_sel = 2'($urandom_range(3));
      if ($urandom_range(7) == 0) cpu_wait = ~cpu_wait;
      if ($urandom_range(63) == 0) wait_run_en = ~wait_run_en;
      cyc();
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule